// File: doc/BRIEF.md
# DMA transfer mode selector

This block chooses the fastest DMA transfer mode that a storage drive and its host controller have in common. It receives the drive's capability words for three DMA classes: Ultra-DMA, multiword DMA and single-word DMA. It also receives a field-validity word, a host capability mask for each class, a flag that reports an 80-conductor cable, a flag that marks the media as a disk, and a flag that permits DMA on packet-command devices.

A single-cycle request starts a selection. The block returns a mode code with a one-cycle valid strobe. The code is the base value of the winning class plus the index of the highest usable mode bit. A code of zero means that no DMA mode is possible.

Top module: `dms_mode_select`

## Requirements
- R1: The classes are tried in the order Ultra-DMA, then multiword, then single-word. The first class whose usable mask is non-empty gives the result.
- R2: The result is the class base code plus the index of the highest set bit of that class's usable mask. The base codes are 0x40 for Ultra-DMA, 0x20 for multiword and 0x10 for single-word.
- R3: The Ultra-DMA class is considered only when bit 2 of the validity word is 1.
- R4: The multiword and single-word classes are considered only when bit 1 of the validity word is 1.
- R5: A class's usable mask is the low 8 bits of the drive capability word ANDed with that class's host mask. The upper 8 bits of each capability word are ignored.
- R6: If the Ultra mask has any of bits 3 to 6 set and the cable flag is 0, the Ultra mask is cut to its bits 0 to 2 before the highest bit is taken. If nothing remains, selection falls through to the next class.
- R7: If the media flag is 0 (not a disk) and the packet-DMA flag is 0, the result is 0. If the packet-DMA flag is 1, the selection runs normally.
- R8: If no class has a usable mask, the result is 0.
- R9: The result appears in the cycle after the request. The valid strobe is high for exactly that one cycle per request.
- R10: After reset the mode output is 0 and the strobe is low. The mode output holds its value while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Single-cycle selection request |
| ultra_cap_i | input | 16 | Drive Ultra-DMA capability word |
| mword_cap_i | input | 16 | Drive multiword DMA capability word |
| sword_cap_i | input | 16 | Drive single-word DMA capability word |
| valid_word_i | input | 16 | Drive field-validity word |
| ultra_host_i | input | 8 | Host Ultra-DMA mode mask |
| mword_host_i | input | 8 | Host multiword mode mask |
| sword_host_i | input | 8 | Host single-word mode mask |
| cable80_i | input | 1 | 80-conductor cable detected |
| media_disk_i | input | 1 | Media is a disk |
| packet_dma_ok_i | input | 1 | DMA allowed on packet devices |
| mode_o | output | 8 | Selected mode code, 0 = no DMA |
| mode_vld_o | output | 1 | One-cycle strobe for a new result |

## Verification
On every cycle, the assertions check several properties:
- the strobe follows the request by exactly one cycle;
- the mode holds while no request is made;
- a non-disk without packet permission yields zero;
- a result in the Ultra class needs validity bit 2, and a result in either older class needs validity bit 1;
- no Ultra mode above 2 is reported without the cable flag.

Only the bench's scenarios can show the exact code for each input pattern. These cover:
- class fallback when a masked or clamped class is empty;
- AND-ing with the host masks;
- indifference to the upper capability bits;
- back-to-back requests.

// File: rtl/dms_pkg.sv
package dms_pkg;
   localparam int unsigned NUM_CLS = 3;
   typedef enum logic [1:0] {
      CLS_ULTRA = 2'd0,
      CLS_MWORD = 2'd1,
      CLS_SWORD = 2'd2
   } dms_cls_e;
endpackage

// File: rtl/dms_class_mask.sv
module dms_class_mask #(
   parameter int unsigned MASK_W   = 8,
   parameter bit          CLAMP_EN = 1'b0,
   parameter int unsigned LOW_KEEP = 3,
   parameter int unsigned CLAMP_HI = 6
) (
   input  logic [MASK_W-1:0] cap_i,
   input  logic [MASK_W-1:0] host_i,
   input  logic              enable_i,
   input  logic              cable80_i,
   output logic [MASK_W-1:0] mask_o
);
   logic [MASK_W-1:0] raw;

   initial begin : p_param_chk
      assert (CLAMP_HI < MASK_W && LOW_KEEP <= CLAMP_HI)
         else $error("dms_class_mask: clamp range outside mask width");
   end

   assign raw = enable_i ? (cap_i & host_i) : '0;

   generate
      if (CLAMP_EN) begin : g_clamp
         localparam int unsigned HI_W = CLAMP_HI - LOW_KEEP + 1;
         logic [MASK_W-1:0] keep_low;
         logic              fast_req;
         assign keep_low = {{(MASK_W-LOW_KEEP){1'b0}}, {LOW_KEEP{1'b1}}};
         assign fast_req = |raw[CLAMP_HI -: HI_W];
         assign mask_o   = (fast_req && !cable80_i) ? (raw & keep_low) : raw;
      end else begin : g_plain
         logic unused_cable;
         assign unused_cable = cable80_i;
         assign mask_o       = raw;
      end
   endgenerate
endmodule

// File: rtl/dms_msb_find.sv
module dms_msb_find #(
   parameter int unsigned MASK_W = 8,
   localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
   input  logic [MASK_W-1:0] mask_i,
   output logic              found_o,
   output logic [IDX_W-1:0]  idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < MASK_W; i++) begin
         if (mask_i[i]) idx_o = IDX_W'(i);
      end
   end
   assign found_o = |mask_i;
endmodule

// File: rtl/dms_mode_select.sv
module dms_mode_select #(
   parameter int unsigned CAP_W      = 16,
   parameter int unsigned MASK_W     = 8,
   parameter int unsigned MODE_W     = 8,
   parameter int unsigned ULTRA_BASE = 8'h40,
   parameter int unsigned MWORD_BASE = 8'h20,
   parameter int unsigned SWORD_BASE = 8'h10,
   parameter int unsigned ULTRA_VBIT = 2,
   parameter int unsigned OLD_VBIT   = 1,
   parameter int unsigned LOW_KEEP   = 3,
   parameter int unsigned CLAMP_HI   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [CAP_W-1:0]  ultra_cap_i,
   input  logic [CAP_W-1:0]  mword_cap_i,
   input  logic [CAP_W-1:0]  sword_cap_i,
   input  logic [CAP_W-1:0]  valid_word_i,
   input  logic [MASK_W-1:0] ultra_host_i,
   input  logic [MASK_W-1:0] mword_host_i,
   input  logic [MASK_W-1:0] sword_host_i,
   input  logic              cable80_i,
   input  logic              media_disk_i,
   input  logic              packet_dma_ok_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              mode_vld_o
);
   import dms_pkg::*;

   localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   initial begin : p_param_chk
      assert (MASK_W <= CAP_W && ULTRA_VBIT < CAP_W && OLD_VBIT < CAP_W)
         else $error("dms_mode_select: mask or validity bit exceeds word width");
      assert (ULTRA_BASE + MASK_W - 1 < (1 << MODE_W))
         else $error("dms_mode_select: mode code overflows MODE_W");
   end

   logic [MASK_W-1:0] cap_a   [NUM_CLS];
   logic [MASK_W-1:0] host_a  [NUM_CLS];
   logic              en_a    [NUM_CLS];
   logic [MASK_W-1:0] mask_a  [NUM_CLS];
   logic              found_a [NUM_CLS];
   logic [IDX_W-1:0]  idx_a   [NUM_CLS];
   logic [MODE_W-1:0] base_a  [NUM_CLS];

   assign cap_a[CLS_ULTRA]  = ultra_cap_i[MASK_W-1:0];
   assign cap_a[CLS_MWORD]  = mword_cap_i[MASK_W-1:0];
   assign cap_a[CLS_SWORD]  = sword_cap_i[MASK_W-1:0];
   assign host_a[CLS_ULTRA] = ultra_host_i;
   assign host_a[CLS_MWORD] = mword_host_i;
   assign host_a[CLS_SWORD] = sword_host_i;
   assign en_a[CLS_ULTRA]   = valid_word_i[ULTRA_VBIT];
   assign en_a[CLS_MWORD]   = valid_word_i[OLD_VBIT];
   assign en_a[CLS_SWORD]   = valid_word_i[OLD_VBIT];
   assign base_a[CLS_ULTRA] = MODE_W'(ULTRA_BASE);
   assign base_a[CLS_MWORD] = MODE_W'(MWORD_BASE);
   assign base_a[CLS_SWORD] = MODE_W'(SWORD_BASE);

   generate
      for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
         dms_class_mask #(
            .MASK_W   (MASK_W),
            .CLAMP_EN (g == CLS_ULTRA),
            .LOW_KEEP (LOW_KEEP),
            .CLAMP_HI (CLAMP_HI)
         ) u_mask (
            .cap_i     (cap_a[g]),
            .host_i    (host_a[g]),
            .enable_i  (en_a[g]),
            .cable80_i (cable80_i),
            .mask_o    (mask_a[g])
         );
         dms_msb_find #(.MASK_W(MASK_W)) u_msb (
            .mask_i  (mask_a[g]),
            .found_o (found_a[g]),
            .idx_o   (idx_a[g])
         );
      end
   endgenerate

   logic              dma_allowed;
   logic [MODE_W-1:0] mode_nxt;

   assign dma_allowed = media_disk_i || packet_dma_ok_i;

   always_comb begin
      mode_nxt = '0;
      for (int c = NUM_CLS - 1; c >= 0; c--) begin
         if (found_a[c]) mode_nxt = base_a[c] + MODE_W'(idx_a[c]);
      end
      if (!dma_allowed) mode_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o     <= '0;
         mode_vld_o <= 1'b0;
      end else begin
         mode_vld_o <= req_i;
         if (req_i) mode_o <= mode_nxt;
      end
   end

   // R9: strobe follows each request by exactly one cycle
   a_r9_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> mode_vld_o);
   a_r9_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !mode_vld_o);
   // R10: no request, no change
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(mode_o));
   // R7: non-disk without packet permission gives zero
   a_r7_no_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !media_disk_i && !packet_dma_ok_i) |=> (mode_o == '0));
   // R3: an Ultra-class result needs validity bit 2
   a_r3_ultra_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !valid_word_i[ULTRA_VBIT]) |=> (mode_o < MODE_W'(ULTRA_BASE)));
   // R4: an older-class result needs validity bit 1
   a_r4_old_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !valid_word_i[OLD_VBIT]) |=>
         (mode_o == '0 || mode_o >= MODE_W'(ULTRA_BASE)));
   // R6: no fast Ultra mode without the cable
   a_r6_cable_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !cable80_i) |=>
         !(mode_o >= MODE_W'(ULTRA_BASE + LOW_KEEP) && mode_o <= MODE_W'(ULTRA_BASE + CLAMP_HI)));
endmodule

// File: tb/dms_mode_select_bench.sv
module dms_mode_select_bench;
   typedef struct packed {
      logic [7:0] ucap;
      logic [7:0] mcap;
      logic [7:0] scap;
      logic [2:0] vld;
      logic [7:0] uh;
      logic [7:0] mh;
      logic [7:0] sh;
      logic       cab;
      logic       disk;
      logic       pkt;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{8'h7F, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h46}, // R1 R2
      '{8'h7F, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h42}, // R6
      '{8'h18, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h22}, // R6 fallthrough
      '{8'h3F, 8'h05, 8'h07, 3'b010, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h22}, // R3
      '{8'h00, 8'h07, 8'h07, 3'b100, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R4 R8
      '{8'h3F, 8'h07, 8'h07, 3'b110, 8'h07, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h42}, // R5
      '{8'h3F, 8'h04, 8'h02, 3'b110, 8'h00, 8'h03, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h11}, // R1 R5
      '{8'h3F, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h00}, // R7
      '{8'h3F, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h45}, // R7
      '{8'h01, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h40}, // R2
      '{8'h00, 8'h00, 8'h00, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h00}, // R8
      '{8'h00, 8'h00, 8'h05, 3'b010, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 8'h12}, // R1 R2
      '{8'h0F, 8'h07, 8'h07, 3'b110, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h42}  // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] ucap = '0, mcap = '0, scap = '0, vword = '0;
   logic [7:0]  uh = '0, mh = '0, sh = '0;
   logic        cab = 1'b0, disk = 1'b0, pkt = 1'b0;
   logic [7:0]  mode;
   logic        vld;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dms_mode_select u_dms_mode_select (
      .clk(clk), .rst_n(rst_n), .req_i(req),
      .ultra_cap_i(ucap), .mword_cap_i(mcap), .sword_cap_i(scap),
      .valid_word_i(vword), .ultra_host_i(uh), .mword_host_i(mh),
      .sword_host_i(sh), .cable80_i(cab), .media_disk_i(disk),
      .packet_dma_ok_i(pkt), .mode_o(mode), .mode_vld_o(vld)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic load(input vec_t v, input logic [7:0] hi);
      ucap  = {hi, v.ucap};
      mcap  = {hi, v.mcap};
      scap  = {hi, v.scap};
      vword = {hi, 5'b0, v.vld};
      uh = v.uh; mh = v.mh; sh = v.sh;
      cab = v.cab; disk = v.disk; pkt = v.pkt;
   endtask

   // drive at negedge, request for one cycle, sample the next negedge
   task automatic run(input vec_t v, input logic [7:0] hi, input string tag);
      @(negedge clk);
      load(v, hi);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check({tag, " strobe R9"}, {7'b0, vld}, 8'h01);
      check(tag, mode, v.exp);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      vec_t v;
      repeat (3) @(negedge clk);
      check("R10 reset mode", mode, 8'h00);
      check("R10 reset strobe", {7'b0, vld}, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run(VEC[i], 8'hA5, $sformatf("vector %0d", i));
      end

      // R9: strobe drops after one cycle; R10: mode held while idle
      v = VEC[0];
      run(v, 8'h00, "R9 single");
      @(negedge clk);
      check("R9 strobe low", {7'b0, vld}, 8'h00);
      load(VEC[10], 8'h00);
      repeat (3) @(negedge clk);
      check("R10 hold idle", mode, 8'h46);

      // R5: upper byte of capability words ignored
      v = VEC[10];
      run(v, 8'hFF, "R5 upper byte");

      // R9: back-to-back requests each produce their own result
      @(negedge clk);
      load(VEC[0], 8'h00);
      req = 1'b1;
      @(negedge clk);
      check("R9 b2b first", mode, 8'h46);
      load(VEC[6], 8'h00);
      @(negedge clk);
      req = 1'b0;
      check("R9 b2b second", mode, 8'h11);
      check("R9 b2b strobe", {7'b0, vld}, 8'h01);
      @(negedge clk);
      check("R9 b2b end", {7'b0, vld}, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule